// File: doc/BRIEF.md
# Precision-time event frame classifier

This block decides, for each frame whose headers have already been extracted, whether the frame is a precision-time-protocol event message. The decision is made in two levels. The first level compares header fields against eleven match parameters. There are fixed IPv4 and IPv6 multicast destinations, two UDP event ports, a fixed EtherType, two fixed multicast MAC destinations, one programmable EtherType and one programmable MAC destination. The second level combines these parameters into fourteen fixed pairwise rules.

Each parameter and each rule can be disabled by its own mask bit. A disabled parameter never matches, so every rule built on it stays silent. IP-based rules also require the frame to carry the matching IP version.

A small write-only configuration port holds both masks, the programmable values and the direction enable bits. A frame is presented for one cycle with `hdr_valid`. One cycle later the block returns a one-cycle decision strobe, a hit flag and the vector of rules that fired.

Top module: `ptpc_top`

## Requirements
- R1: After reset the parameter mask and rule mask are all ones and the direction register is zero, so no rule fires and `ptp_hit` is 0 for any frame.
- R2: With `is_ipv4`=1, IPv4 destination 224.0.1.129 (param 0) or 224.0.0.107 (param 1) in `ip_da[31:0]`, paired with UDP port 319 (param 4) or 320 (param 5) with `udp_vld`=1, fires rule bit 0 {p0,p4}, 1 {p0,p5}, 2 {p1,p4} or 3 {p1,p5} of `rule_hits`.
- R3: With `is_ipv6`=1, destination FF0x::181 (param 2, bits 115:112 ignored) or FF02::6B (param 3), paired with port 319 or 320, fires rule bits 4 {p2,p4}, 5 {p2,p5}, 6 {p3,p4}, 7 {p3,p5}; any other value of bits 119:116 does not match param 2.
- R4: MAC destination 01-1B-19-00-00-00 (param 8) or 01-80-C2-00-00-0E (param 9) with EtherType 0x88F7 (param 6) fires rule bit 8 or 9 respectively.
- R5: The configuration port writes on `cfg_we` at `cfg_addr`: 0 parameter mask [10:0], 1 rule mask [13:0], 2 programmable EtherType (param 7) [15:0], 3 programmable MAC [31:0], 4 programmable MAC [47:32], 5 direction bits {v2_on,v1_on,enable} in [2:0]. Rules 10 {p8,p7}, 11 {p9,p7}, 12 {p10,p6} and 13 {p10,p7} use the programmable values (param 10 is the programmable MAC).
- R6: A parameter mask bit of 1 makes that parameter never match, so every rule using it stays clear while rules not using it still fire.
- R7: A rule mask bit of 1 keeps that rule bit clear in `rule_hits` and out of `ptp_hit`.
- R8: Rules 0 to 3 fire only when `is_ipv4`=1, and rules 4 to 7 only when `is_ipv6`=1, even if the address fields match.
- R9: `ptp_hit` is 1 only if some rule fires, direction `enable` is 1, and either `ptp_ver`=1 with `v1_on`=1 or `ptp_ver`=2 with `v2_on`=1. `rule_hits` itself is not qualified by the direction bits.
- R10: `result_vld`, `ptp_hit` and `rule_hits` are registered one cycle after `hdr_valid`, and they last one cycle. When `result_vld` is 0, `ptp_hit` and `rule_hits` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Header fields below are valid this cycle |
| mac_da | input | 48 | Destination MAC address |
| eth_type | input | 16 | EtherType |
| is_ipv4 | input | 1 | Frame carries IPv4 |
| is_ipv6 | input | 1 | Frame carries IPv6 |
| ip_da | input | 128 | IP destination; IPv4 in bits 31:0 |
| udp_vld | input | 1 | A UDP header is present |
| udp_dport | input | 16 | UDP destination port |
| ptp_ver | input | 4 | Protocol version field of the message |
| result_vld | output | 1 | Decision strobe |
| ptp_hit | output | 1 | Frame is a qualified event message |
| rule_hits | output | 14 | Unmasked rules that fired, bit n = rule n |

## Verification
Every address and port pairing is applied one at a time, and the test checks that exactly the expected rule bit appears. This separates the pair ordering from the parameter ordering. Near-miss frames check the edges of each match:
- the IPv6 wildcard nibble against the nibble that must match;
- IPv4 addresses in IPv6 frames;
- frames whose only difference is the EtherType or the MAC.

Mask tests set one bit and show that only the rules depending on it go quiet. The direction tests keep one frame fixed and change only the enable and version bits. This shows that these bits gate the hit and leave the rule vector alone.

// File: rtl/ptpc_pkg.sv
// Shared constants, types and rule table for the event frame classifier.
package ptpc_pkg;

    localparam int N_PARAM = 11;
    localparam int N_RULE  = 14;

    // Parameter indices (the rule table depends on this order)
    localparam int P_V4_A   = 0;
    localparam int P_V4_B   = 1;
    localparam int P_V6_A   = 2;
    localparam int P_V6_B   = 3;
    localparam int P_PORT_A = 4;
    localparam int P_PORT_B = 5;
    localparam int P_ET_A   = 6;
    localparam int P_ET_B   = 7;
    localparam int P_MAC_A  = 8;
    localparam int P_MAC_B  = 9;
    localparam int P_MAC_C  = 10;

    // Configuration register select codes
    typedef enum logic [2:0] {
        CFG_PMASK  = 3'd0,
        CFG_RMASK  = 3'd1,
        CFG_ETYPE  = 3'd2,
        CFG_MAC_LO = 3'd3,
        CFG_MAC_HI = 3'd4,
        CFG_DIR    = 3'd5
    } cfg_sel_e;

    typedef enum logic [1:0] {
        RK_V4 = 2'd0,
        RK_V6 = 2'd1,
        RK_L2 = 2'd2
    } rule_kind_e;

    typedef struct packed {
        logic v2_on;
        logic v1_on;
        logic enable;
    } dir_cfg_t;

    // Address-type parameter used by rule r
    function automatic int rule_left(input int r);
        int k;
        if (r < 4) return P_V4_A + r / 2;
        if (r < 8) return P_V6_A + (r - 4) / 2;
        k = r - 8;
        if (k < 4) return P_MAC_A + k % 2;
        return P_MAC_C;
    endfunction

    // Port or type parameter used by rule r
    function automatic int rule_right(input int r);
        int k;
        if (r < 8) return P_PORT_A + r % 2;
        k = r - 8;
        if (k < 4) return P_ET_A + k / 2;
        return P_ET_A + k % 2;
    endfunction

    function automatic rule_kind_e rule_kind(input int r);
        if (r < 4) return RK_V4;
        if (r < 8) return RK_V6;
        return RK_L2;
    endfunction

endpackage

// File: rtl/ptpc_cfg.sv
// Configuration register file. It holds the masks, the programmable
// EtherType and MAC, and the direction bits. Writes take effect on the
// next cycle. Assumes MAC_W lies between 33 and 64 bits.
module ptpc_cfg
    import ptpc_pkg::*;
#(
    parameter int CFG_AW  = 3,
    parameter int CFG_DW  = 32,
    parameter int MAC_W   = 48,
    parameter int ETYPE_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [N_PARAM-1:0]   param_mask,
    output logic [N_RULE-1:0]    rule_mask,
    output logic [ETYPE_W-1:0]   cust_etype,
    output logic [MAC_W-1:0]     cust_mac,
    output dir_cfg_t             dir_cfg
);

    localparam int MAC_HI_W = MAC_W - CFG_DW;

    // Register update on a configuration write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            param_mask <= '1;
            rule_mask  <= '1;
            cust_etype <= '0;
            cust_mac   <= '0;
            dir_cfg    <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_addr))
                CFG_PMASK:  param_mask <= cfg_wdata[N_PARAM-1:0];
                CFG_RMASK:  rule_mask  <= cfg_wdata[N_RULE-1:0];
                CFG_ETYPE:  cust_etype <= cfg_wdata[ETYPE_W-1:0];
                CFG_MAC_LO: cust_mac[CFG_DW-1:0] <= cfg_wdata;
                CFG_MAC_HI: cust_mac[MAC_W-1:CFG_DW] <= cfg_wdata[MAC_HI_W-1:0];
                CFG_DIR:    dir_cfg <= dir_cfg_t'(cfg_wdata[2:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ptpc_param_match.sv
// First level: compares the header fields against the eleven match
// parameters. A masked parameter reports no match. The IP address
// parameters do not look at the IP version; rules apply that gate.
module ptpc_param_match
    import ptpc_pkg::*;
#(
    parameter int MAC_W   = 48,
    parameter int ETYPE_W = 16,
    parameter int PORT_W  = 16,
    parameter int IP_W    = 128
) (
    input  logic [MAC_W-1:0]   mac_da,
    input  logic [ETYPE_W-1:0] eth_type,
    input  logic [IP_W-1:0]    ip_da,
    input  logic               udp_vld,
    input  logic [PORT_W-1:0]  udp_dport,
    input  logic [ETYPE_W-1:0] cust_etype,
    input  logic [MAC_W-1:0]   cust_mac,
    input  logic [N_PARAM-1:0] param_mask,
    output logic [N_PARAM-1:0] param_hit
);

    localparam logic [31:0]      V4_A      = 32'hE000_0181;
    localparam logic [31:0]      V4_B      = 32'hE000_006B;
    localparam logic [IP_W-1:0]  V6_A_VAL  = 128'hFF00_0000_0000_0000_0000_0000_0000_0181;
    localparam logic [IP_W-1:0]  V6_A_CARE = 128'hFFF0_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
    localparam logic [IP_W-1:0]  V6_B      = 128'hFF02_0000_0000_0000_0000_0000_0000_006B;
    localparam logic [PORT_W-1:0] PORT_A   = PORT_W'(319);
    localparam logic [PORT_W-1:0] PORT_B   = PORT_W'(320);
    localparam logic [ETYPE_W-1:0] ET_A    = ETYPE_W'(16'h88F7);
    localparam logic [MAC_W-1:0]  MAC_A    = MAC_W'(48'h011B_1900_0000);
    localparam logic [MAC_W-1:0]  MAC_B    = MAC_W'(48'h0180_C200_000E);

    logic [N_PARAM-1:0] raw;

    // Raw field comparisons, one per parameter
    always_comb begin
        raw           = '0;
        raw[P_V4_A]   = (ip_da[31:0] == V4_A);
        raw[P_V4_B]   = (ip_da[31:0] == V4_B);
        raw[P_V6_A]   = ((ip_da & V6_A_CARE) == V6_A_VAL);
        raw[P_V6_B]   = (ip_da == V6_B);
        raw[P_PORT_A] = udp_vld && (udp_dport == PORT_A);
        raw[P_PORT_B] = udp_vld && (udp_dport == PORT_B);
        raw[P_ET_A]   = (eth_type == ET_A);
        raw[P_ET_B]   = (eth_type == cust_etype);
        raw[P_MAC_A]  = (mac_da == MAC_A);
        raw[P_MAC_B]  = (mac_da == MAC_B);
        raw[P_MAC_C]  = (mac_da == cust_mac);
    end

    // Masked parameters are forced to no-match
    always_comb param_hit = raw & ~param_mask;

endmodule

// File: rtl/ptpc_rule_net.sv
// Second level: builds the fourteen fixed pairwise rules from the
// parameter hits. IP rules are gated on the IP version flag, and the
// rule mask is then applied.
module ptpc_rule_net
    import ptpc_pkg::*;
(
    input  logic [N_PARAM-1:0] param_hit,
    input  logic               is_ipv4,
    input  logic               is_ipv6,
    input  logic [N_RULE-1:0]  rule_mask,
    output logic [N_RULE-1:0]  rule_fire
);

    logic [N_RULE-1:0] pair_hit;

    for (genvar r = 0; r < N_RULE; r++) begin : g_rule
        localparam int         LI   = rule_left(r);
        localparam int         RI   = rule_right(r);
        localparam rule_kind_e KIND = rule_kind(r);
        logic gate;
        if (KIND == RK_V4) begin : g_v4
            assign gate = is_ipv4;
        end else if (KIND == RK_V6) begin : g_v6
            assign gate = is_ipv6;
        end else begin : g_l2
            assign gate = 1'b1;
        end
        assign pair_hit[r] = gate && param_hit[LI] && param_hit[RI];
    end

    // Rule mask removes disabled rules
    always_comb rule_fire = pair_hit & ~rule_mask;

endmodule

// File: rtl/ptpc_top.sv
// Event frame classifier top. It registers the decision one cycle after
// hdr_valid. It assumes the header fields are stable while hdr_valid is high.
module ptpc_top
    import ptpc_pkg::*;
#(
    parameter int CFG_AW  = 3,
    parameter int CFG_DW  = 32,
    parameter int MAC_W   = 48,
    parameter int ETYPE_W = 16,
    parameter int PORT_W  = 16,
    parameter int IP_W    = 128,
    parameter int VER_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    input  logic               hdr_valid,
    input  logic [MAC_W-1:0]   mac_da,
    input  logic [ETYPE_W-1:0] eth_type,
    input  logic               is_ipv4,
    input  logic               is_ipv6,
    input  logic [IP_W-1:0]    ip_da,
    input  logic               udp_vld,
    input  logic [PORT_W-1:0]  udp_dport,
    input  logic [VER_W-1:0]   ptp_ver,
    output logic               result_vld,
    output logic               ptp_hit,
    output logic [N_RULE-1:0]  rule_hits
);

    logic [N_PARAM-1:0] param_mask_q;
    logic [N_RULE-1:0]  rule_mask_q;
    logic [ETYPE_W-1:0] cust_etype_q;
    logic [MAC_W-1:0]   cust_mac_q;
    dir_cfg_t           dir_en_q;
    logic [N_PARAM-1:0] param_hit;
    logic [N_RULE-1:0]  rule_fire;
    logic               ver_ok;
    logic               hit_comb;

    ptpc_cfg #(
        .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .MAC_W(MAC_W), .ETYPE_W(ETYPE_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .param_mask (param_mask_q),
        .rule_mask  (rule_mask_q),
        .cust_etype (cust_etype_q),
        .cust_mac   (cust_mac_q),
        .dir_cfg    (dir_en_q)
    );

    ptpc_param_match #(
        .MAC_W(MAC_W), .ETYPE_W(ETYPE_W), .PORT_W(PORT_W), .IP_W(IP_W)
    ) u_match (
        .mac_da     (mac_da),
        .eth_type   (eth_type),
        .ip_da      (ip_da),
        .udp_vld    (udp_vld),
        .udp_dport  (udp_dport),
        .cust_etype (cust_etype_q),
        .cust_mac   (cust_mac_q),
        .param_mask (param_mask_q),
        .param_hit  (param_hit)
    );

    ptpc_rule_net u_rules (
        .param_hit (param_hit),
        .is_ipv4   (is_ipv4),
        .is_ipv6   (is_ipv6),
        .rule_mask (rule_mask_q),
        .rule_fire (rule_fire)
    );

    // Version qualification from the direction bits
    always_comb begin
        ver_ok   = (dir_en_q.v1_on && ptp_ver == VER_W'(1)) ||
                   (dir_en_q.v2_on && ptp_ver == VER_W'(2));
        hit_comb = dir_en_q.enable && ver_ok && (|rule_fire);
    end

    // Output register: one-cycle decision strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_vld <= 1'b0;
            ptp_hit    <= 1'b0;
            rule_hits  <= '0;
        end else begin
            result_vld <= hdr_valid;
            ptp_hit    <= hdr_valid && hit_comb;
            rule_hits  <= hdr_valid ? rule_fire : '0;
        end
    end

endmodule

// File: rtl/ptpc_chk.sv
// Property checker for ptpc_top, attached by bind below.
module ptpc_chk
    import ptpc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               hdr_valid,
    input logic               is_ipv4,
    input logic               is_ipv6,
    input logic               result_vld,
    input logic               ptp_hit,
    input logic [N_RULE-1:0]  rule_hits,
    input logic [N_RULE-1:0]  rule_mask,
    input logic [N_PARAM-1:0] param_mask,
    input logic [2:0]         dir_en
);

    assert_reset_masks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (param_mask == '1 && rule_mask == '1 && dir_en == 3'b0));

    assert_rule_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> ((rule_hits & $past(rule_mask)) == '0));

    assert_v4_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld && !$past(is_ipv4)) |-> (rule_hits[3:0] == 4'b0));

    assert_v6_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld && !$past(is_ipv6)) |-> (rule_hits[7:4] == 4'b0));

    assert_hit_needs_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptp_hit |-> (rule_hits != '0));

    assert_hit_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld && !$past(dir_en[0])) |-> !ptp_hit);

    assert_strobe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> result_vld);

    assert_strobe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !result_vld);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld |-> (!ptp_hit && rule_hits == '0));

endmodule

bind ptpc_top ptpc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_valid  (hdr_valid),
    .is_ipv4    (is_ipv4),
    .is_ipv6    (is_ipv6),
    .result_vld (result_vld),
    .ptp_hit    (ptp_hit),
    .rule_hits  (rule_hits),
    .rule_mask  (rule_mask_q),
    .param_mask (param_mask_q),
    .dir_en     (dir_en_q)
);

// File: tb/ptpc_top_tb.sv
module ptpc_top_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [47:0]  MAC0   = 48'h011B_1900_0000;
    localparam logic [47:0]  MAC1   = 48'h0180_C200_000E;
    localparam logic [47:0]  MACX   = 48'h02AA_BBCC_DDEE;
    localparam logic [47:0]  MACN   = 48'h0000_0000_0001;
    localparam logic [15:0]  ET0    = 16'h88F7;
    localparam logic [15:0]  ETX    = 16'h1234;
    localparam logic [15:0]  ETN    = 16'h0800;
    localparam logic [127:0] V4A    = 128'hE000_0181;
    localparam logic [127:0] V4B    = 128'hE000_006B;
    localparam logic [127:0] V6A    = 128'hFF05_0000_0000_0000_0000_0000_0000_0181;
    localparam logic [127:0] V6AW   = 128'hFF0E_0000_0000_0000_0000_0000_0000_0181;
    localparam logic [127:0] V6BAD  = 128'hFF15_0000_0000_0000_0000_0000_0000_0181;
    localparam logic [127:0] V6B    = 128'hFF02_0000_0000_0000_0000_0000_0000_006B;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_we;
    logic [2:0]   cfg_addr;
    logic [31:0]  cfg_wdata;
    logic         hdr_valid;
    logic [47:0]  mac_da;
    logic [15:0]  eth_type;
    logic         is_ipv4;
    logic         is_ipv6;
    logic [127:0] ip_da;
    logic         udp_vld;
    logic [15:0]  udp_dport;
    logic [3:0]   ptp_ver;
    logic         result_vld;
    logic         ptp_hit;
    logic [13:0]  rule_hits;

    int n_checks = 0;
    int n_bad    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptpc_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .mac_da(mac_da),
        .eth_type(eth_type), .is_ipv4(is_ipv4), .is_ipv6(is_ipv6),
        .ip_da(ip_da), .udp_vld(udp_vld), .udp_dport(udp_dport),
        .ptp_ver(ptp_ver), .result_vld(result_vld), .ptp_hit(ptp_hit),
        .rule_hits(rule_hits)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one frame; return at the negedge after the result register loads
    task automatic classify(input logic [47:0] m, input logic [15:0] et,
                            input logic v4, input logic v6, input logic [127:0] ip,
                            input logic uv, input logic [15:0] port, input logic [3:0] ver);
        @(negedge clk);
        hdr_valid = 1'b1; mac_da = m; eth_type = et; is_ipv4 = v4; is_ipv6 = v6;
        ip_da = ip; udp_vld = uv; udp_dport = port; ptp_ver = ver;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 idle strobe", {31'b0, result_vld}, 32'd0);
        classify(MACN, ETN, 1'b1, 1'b0, V4A, 1'b1, 16'd319, 4'd2);
        check("R1 strobe", {31'b0, result_vld}, 32'd1);
        check("R1 rules after reset", {18'b0, rule_hits}, 32'd0);
        check("R1 hit after reset", {31'b0, ptp_hit}, 32'd0);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R1 L2 rules after reset", {18'b0, rule_hits}, 32'd0);
    endtask

    task automatic t_open();
        cfg_write(3'd0, 32'h0);
        cfg_write(3'd1, 32'h0);
        cfg_write(3'd5, 32'h7);
        cfg_write(3'd2, {16'b0, ETX});
        cfg_write(3'd3, MACX[31:0]);
        cfg_write(3'd4, {16'b0, MACX[47:32]});
    endtask

    task automatic t_ipv4();
        classify(MACN, ETN, 1'b1, 1'b0, V4A, 1'b1, 16'd319, 4'd2);
        check("R2 rule0", {18'b0, rule_hits}, 32'h1);
        check("R2 rule0 hit", {31'b0, ptp_hit}, 32'd1);
        classify(MACN, ETN, 1'b1, 1'b0, V4A, 1'b1, 16'd320, 4'd2);
        check("R2 rule1", {18'b0, rule_hits}, 32'h2);
        classify(MACN, ETN, 1'b1, 1'b0, V4B, 1'b1, 16'd319, 4'd2);
        check("R2 rule2", {18'b0, rule_hits}, 32'h4);
        classify(MACN, ETN, 1'b1, 1'b0, V4B, 1'b1, 16'd320, 4'd2);
        check("R2 rule3", {18'b0, rule_hits}, 32'h8);
        classify(MACN, ETN, 1'b1, 1'b0, V4A, 1'b0, 16'd319, 4'd2);
        check("R2 no udp", {18'b0, rule_hits}, 32'h0);
        classify(MACN, ETN, 1'b1, 1'b0, V4A, 1'b1, 16'd321, 4'd2);
        check("R2 wrong port", {31'b0, ptp_hit}, 32'd0);
    endtask

    task automatic t_ipv6();
        classify(MACN, ETN, 1'b0, 1'b1, V6A, 1'b1, 16'd319, 4'd2);
        check("R3 rule4", {18'b0, rule_hits}, 32'h10);
        classify(MACN, ETN, 1'b0, 1'b1, V6AW, 1'b1, 16'd320, 4'd2);
        check("R3 rule5 wildcard", {18'b0, rule_hits}, 32'h20);
        classify(MACN, ETN, 1'b0, 1'b1, V6B, 1'b1, 16'd319, 4'd2);
        check("R3 rule6", {18'b0, rule_hits}, 32'h40);
        classify(MACN, ETN, 1'b0, 1'b1, V6B, 1'b1, 16'd320, 4'd2);
        check("R3 rule7", {18'b0, rule_hits}, 32'h80);
        classify(MACN, ETN, 1'b0, 1'b1, V6BAD, 1'b1, 16'd319, 4'd2);
        check("R3 fixed nibble", {18'b0, rule_hits}, 32'h0);
    endtask

    task automatic t_l2();
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R4 rule8", {18'b0, rule_hits}, 32'h100);
        classify(MAC1, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R4 rule9", {18'b0, rule_hits}, 32'h200);
        classify(MAC0, ETN, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R4 wrong type", {18'b0, rule_hits}, 32'h0);
    endtask

    task automatic t_prog();
        classify(MAC0, ETX, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R5 rule10", {18'b0, rule_hits}, 32'h400);
        classify(MAC1, ETX, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R5 rule11", {18'b0, rule_hits}, 32'h800);
        classify(MACX, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R5 rule12", {18'b0, rule_hits}, 32'h1000);
        classify(MACX, ETX, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R5 rule13", {18'b0, rule_hits}, 32'h2000);
        cfg_write(3'd4, 32'h0000_0003);
        classify(MACX, ETX, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R5 mac high word", {18'b0, rule_hits}, 32'h0);
        cfg_write(3'd4, {16'b0, MACX[47:32]});
    endtask

    task automatic t_param_mask();
        cfg_write(3'd0, 32'h10);
        classify(MACN, ETN, 1'b1, 1'b0, V4A, 1'b1, 16'd319, 4'd2);
        check("R6 port319 masked", {18'b0, rule_hits}, 32'h0);
        classify(MACN, ETN, 1'b1, 1'b0, V4A, 1'b1, 16'd320, 4'd2);
        check("R6 port320 unaffected", {18'b0, rule_hits}, 32'h2);
        cfg_write(3'd0, 32'h40);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R6 ethertype masked", {18'b0, rule_hits}, 32'h0);
        classify(MAC0, ETX, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R6 custom type unaffected", {18'b0, rule_hits}, 32'h400);
        cfg_write(3'd0, 32'h0);
    endtask

    task automatic t_rule_mask();
        cfg_write(3'd1, 32'h100);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R7 rule8 masked bits", {18'b0, rule_hits}, 32'h0);
        check("R7 rule8 masked hit", {31'b0, ptp_hit}, 32'd0);
        classify(MAC1, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R7 rule9 still fires", {18'b0, rule_hits}, 32'h200);
        cfg_write(3'd1, 32'h0);
    endtask

    task automatic t_gate();
        classify(MACN, ETN, 1'b0, 1'b1, V4A, 1'b1, 16'd319, 4'd2);
        check("R8 v4 addr in v6 frame", {18'b0, rule_hits}, 32'h0);
        classify(MACN, ETN, 1'b1, 1'b0, V6A, 1'b1, 16'd319, 4'd2);
        check("R8 v6 addr in v4 frame", {18'b0, rule_hits}, 32'h0);
        classify(MACN, ETN, 1'b0, 1'b0, V4A, 1'b1, 16'd319, 4'd2);
        check("R8 no ip flag", {31'b0, ptp_hit}, 32'd0);
    endtask

    task automatic t_dir();
        cfg_write(3'd5, 32'h5);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd1);
        check("R9 v1 off hit", {31'b0, ptp_hit}, 32'd0);
        check("R9 rules unqualified", {18'b0, rule_hits}, 32'h100);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R9 v2 on hit", {31'b0, ptp_hit}, 32'd1);
        cfg_write(3'd5, 32'h3);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd1);
        check("R9 v1 on hit", {31'b0, ptp_hit}, 32'd1);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd3);
        check("R9 other version", {31'b0, ptp_hit}, 32'd0);
        cfg_write(3'd5, 32'h6);
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R9 enable off", {31'b0, ptp_hit}, 32'd0);
        cfg_write(3'd5, 32'h7);
    endtask

    task automatic t_timing();
        classify(MAC0, ET0, 1'b0, 1'b0, '0, 1'b0, 16'd0, 4'd2);
        check("R10 strobe", {31'b0, result_vld}, 32'd1);
        check("R10 hit", {31'b0, ptp_hit}, 32'd1);
        @(negedge clk);
        check("R10 strobe one cycle", {31'b0, result_vld}, 32'd0);
        check("R10 hit one cycle", {31'b0, ptp_hit}, 32'd0);
        check("R10 rules cleared", {18'b0, rule_hits}, 32'h0);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        hdr_valid = 1'b0; mac_da = '0; eth_type = '0; is_ipv4 = 1'b0;
        is_ipv6 = 1'b0; ip_da = '0; udp_vld = 1'b0; udp_dport = '0; ptp_ver = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open();
        t_ipv4();
        t_ipv6();
        t_l2();
        t_prog();
        t_param_mask();
        t_rule_mask();
        t_gate();
        t_dir();
        t_timing();
        finish_up();
    end

endmodule